// File: doc/BRIEF.md
# Dual-Mode Set/Reset Latch Bank

A bank of storage cells sharing one active-low load strobe and one active-low asynchronous clear. Each cell has its own data input and its own active-low set input. Holding a cell's set input low makes it behave as a D-type storage cell: it captures its data input whenever the strobe is active. Driving the set input from logic turns the cell into a set/reset cell. In that mode, data low clears the cell, data high with set low sets it, and data high with set high keeps it. Data low always wins over set.

The cells are modelled as flip-flops on a system clock, so no latches are inferred. While the strobe is low, the next-state rule is applied to every cell at each rising clock edge. While the strobe is high, every cell keeps its value. The clear acts at once, with no clock, and overrides everything else for as long as it is held low.

Top module: `srd_latch_bank`

## Requirements
- R1: While `clr_n` is low, every bit of `q` is 0. A falling `clr_n` clears `q` without waiting for a clock edge.
- R2: While `clr_n` is low, `load_n`, `din` and `set_n` have no effect, and `q` stays all zero.
- R3: A rising edge sampled with `load_n` high leaves `q` unchanged, whatever `din` and `set_n` are.
- R4: A rising edge sampled with `load_n` low clears every cell whose `din` bit is 0. This holds whatever that cell's `set_n` bit is, so data low dominates set.
- R5: A rising edge sampled with `load_n` low sets to 1 every cell whose `din` bit is 1 and whose `set_n` bit is 0.
- R6: A rising edge sampled with `load_n` low leaves unchanged every cell whose `din` bit and `set_n` bit are both 1.
- R7: With `set_n` held all zero and `load_n` low, `q` equals the `din` value sampled at the previous rising edge (D-type mode).
- R8: Bit i of `q` depends only on bit i of `din` and bit i of `set_n`. Cells in different modes update independently in the same cycle.
- R9: When `load_n` returns high, `q` keeps the value written by the last edge at which `load_n` was low.
- R10: After `clr_n` rises, the first rising edge sampled with `load_n` low loads the cells normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| clr_n | input | 1 | Asynchronous clear of all cells, active low |
| load_n | input | 1 | Shared load strobe, active low |
| din | input | CELLS | Per-cell data input |
| set_n | input | CELLS | Per-cell set input, active low |
| q | output | CELLS | Stored cell values |

## Verification
The bench builds the bank with the default `CELLS = 4`. At this width all sixteen patterns of `din`, of `set_n` and of the prior stored value can be crossed exhaustively. That gives 4096 single-edge cases, which are checked against an independent next-state formula. Because the four cells take different combinations in the same cycle, the sweep also shows that each cell uses only its own inputs. Separate directed tasks cover the asynchronous clear taking effect mid-cycle, clear overriding an active strobe, and the first load after clear is released.

// File: rtl/srd_pkg.sv
package srd_pkg;

    // Action chosen for one cell when the strobe is active.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_SET   = 2'd2
    } cell_act_e;

endpackage

// File: rtl/srd_cell_rule.sv
module srd_cell_rule
    import srd_pkg::*;
(
    input  logic      din,
    input  logic      set_n,
    output cell_act_e act
);

    // Data low dominates; otherwise an active set forces one.
    always_comb begin
        if (!din)
            act = ACT_CLEAR;
        else if (!set_n)
            act = ACT_SET;
        else
            act = ACT_HOLD;
    end

endmodule

// File: rtl/srd_latch_bank.sv
module srd_latch_bank
    import srd_pkg::*;
#(
    parameter int CELLS = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [CELLS-1:0] din,
    input  logic [CELLS-1:0] set_n,
    output logic [CELLS-1:0] q
);

    localparam logic [CELLS-1:0] ALL_ZERO = '0;

    typedef struct packed {
        logic [CELLS-1:0] bits;
    } bank_st_t;

    bank_st_t  st_d, st_q;
    cell_act_e act [CELLS];

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        srd_cell_rule u_rule (
            .din   (din[i]),
            .set_n (set_n[i]),
            .act   (act[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (!load_n) begin
            for (int i = 0; i < CELLS; i++) begin
                case (act[i])
                    ACT_CLEAR: st_d.bits[i] = 1'b0;
                    ACT_SET:   st_d.bits[i] = 1'b1;
                    default:   st_d.bits[i] = st_q.bits[i];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            st_q <= '{bits: ALL_ZERO};
        else
            st_q <= st_d;
    end

    assign q = st_q.bits;

    always @(posedge clk) begin
        if (!clr_n) begin
            AST_CLEAR_ZERO: assert (q == ALL_ZERO); // R1
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
        load_n |=> $stable(q)); // R3

    AST_DATA_LOW_CLEARS: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> ((q & ~$past(din)) == ALL_ZERO)); // R4

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> ((q & $past(din & ~set_n)) == $past(din & ~set_n))); // R5

    AST_BOTH_HIGH_KEEP: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (((q ^ $past(q)) & $past(din & set_n)) == ALL_ZERO)); // R6

endmodule

// File: tb/sim_srd_latch_bank.sv
module sim_srd_latch_bank;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         clr_n;
    logic         load_n;
    logic [N-1:0] din;
    logic [N-1:0] set_n;
    logic [N-1:0] q;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    srd_latch_bank #(.CELLS(N)) u0 (
        .clk    (clk),
        .clr_n  (clr_n),
        .load_n (load_n),
        .din    (din),
        .set_n  (set_n),
        .q      (q)
    );

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Each task starts and ends just after a falling clock edge.
    task automatic preload(input logic [N-1:0] pat);
        load_n = 1'b0; set_n = '0; din = pat;
        @(negedge clk);
        load_n = 1'b1;
    endtask

    task automatic t_reset_state;
        clr_n = 1'b0; load_n = 1'b0; din = '1; set_n = '0;
        @(negedge clk);
        check("R1 reset state", q, '0);
        @(negedge clk);
        check("R2 strobe ignored in clear", q, '0);
        // R10: release clear, load on the very next edge
        clr_n = 1'b1; din = 4'hA; set_n = '0; load_n = 1'b0;
        @(negedge clk);
        check("R10 first load after clear", q, 4'hA);
        load_n = 1'b1;
    endtask

    task automatic t_async_clear;
        preload(4'hF);
        check("R1 preload", q, 4'hF);
        #1 clr_n = 1'b0;
        #1 check("R1 async clear mid-cycle", q, '0);
        load_n = 1'b0; din = 4'hF; set_n = 4'h0;
        @(negedge clk);
        check("R2 clear overrides set", q, '0);
        clr_n = 1'b1; load_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_idle_hold;
        preload(4'h6);
        for (int k = 0; k < 16; k++) begin
            load_n = 1'b1; din = 4'(k); set_n = 4'(15 - k);
            @(negedge clk);
            check("R3 inputs ignored while idle", q, 4'h6);
        end
    endtask

    task automatic t_dmode;
        logic [N-1:0] seq [6] = '{4'h3, 4'hC, 4'h0, 4'hF, 4'h5, 4'h9};
        set_n = '0; load_n = 1'b0;
        foreach (seq[k]) begin
            din = seq[k];
            @(negedge clk);
            check("R7 follows data", q, seq[k]);
        end
        load_n = 1'b1; din = 4'h0;
        @(negedge clk);
        @(negedge clk);
        check("R9 holds last loaded value", q, 4'h9);
    endtask

    task automatic t_exhaustive;
        for (int p = 0; p < 16; p++) begin
            for (int d = 0; d < 16; d++) begin
                for (int s = 0; s < 16; s++) begin
                    logic [N-1:0] exp;
                    preload(4'(p));
                    exp = 4'(d) & (~4'(s) | 4'(p));
                    load_n = 1'b0; din = 4'(d); set_n = 4'(s);
                    @(negedge clk);
                    check("R4/R5/R6/R8 next state", q, exp);
                end
            end
        end
        load_n = 1'b1;
    endtask

    initial begin
        clr_n = 1'b0; load_n = 1'b1; din = '0; set_n = '1;
        @(negedge clk);
        t_reset_state();
        t_async_clear();
        t_idle_hold();
        t_dmode();
        t_exhaustive();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule